// File: doc/BRIEF.md
# Regulator Startup and Power-Good Sequencer

This block is the digital sequencer of a multi-phase core-voltage regulator. After the enable input rises it holds the power stage off for a soft-start delay, lets the output ramp, and then holds a fixed boot voltage target for a while. Only then does it release the processor clock through an active-low clock-enable output and, some time later, raise power-good. In graphics-load mode the boot step is skipped: the DAC target is the programmed VID from the start, and the clock is released as soon as the ramp completes.

Once power-good is high, the block watches digitized undervoltage and overvoltage comparator results, which together form the output window. It blanks that window check for a fixed time after every VID change and every new over-current event. A fault that lasts long enough, a sustained over-current or a crowbar event forces a latchoff. In latchoff, switching stops and power-good stays low until enable is taken low and raised again. All delays are parameters counted in clock cycles.

Top module: `vreg_seq_ctrl`

## Requirements
- R1: During reset, and whenever enable is low, `sw_en_o`=0, `pgood_o`=0, `clk_en_n_o`=1 and `latch_o`=0.
- R2: `sw_en_o` rises on the (SS_DLY+1)-th rising clock edge after enable is driven high. One edge samples enable, then SS_DLY edges of soft-start follow.
- R3: In normal mode (`gpu_mode_i`=0), `dac_vid_o`=0 (boot target) until the clock is released. `clk_en_n_o` falls, and `dac_vid_o` becomes 1, on the (BOOT_DLY+1)-th edge after `ramp_done_i` is driven high.
- R4: In graphics mode (`gpu_mode_i`=1), `dac_vid_o`=1 throughout, and `clk_en_n_o` falls on the first edge that samples `ramp_done_i` high.
- R5: `pgood_o` rises PG_DLY edges after `clk_en_n_o` falls.
- R6: While power-good is up and unmasked, `uv_i` or `ov_i` high drops `pgood_o` in the same cycle. `pgood_o` returns when both clear, unless latchoff has occurred.
- R7: A `vid_chg_i` pulse, or a rising edge of `ocp_i`, masks window faults in that cycle and for the next MASK_DLY cycles.
- R8: An unmasked window fault held for WIN_DLY consecutive edges forces latchoff: `latch_o`=1, `sw_en_o`=0, `pgood_o`=0, `clk_en_n_o`=1. A shorter fault does not.
- R9: `ocp_i` held high for OCP_DLY consecutive edges while switching forces latchoff. A shorter pulse does not.
- R10: `crowbar_i` held for CB_DLY edges forces latchoff in any enabled state from soft-start onward. Crowbar is never masked.
- R11: Enable low forces the R1 state on the next edge from any state. A later rising enable restarts the full sequence.
- R12: Latchoff is sticky while enable stays high, whatever the fault inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable |
| gpu_mode_i | input | 1 | Graphics-load mode, skips the boot step |
| ramp_done_i | input | 1 | Soft-start ramp has reached its target |
| vid_chg_i | input | 1 | One-cycle pulse on any VID code change |
| ocp_i | input | 1 | Over-current comparator, level |
| uv_i | input | 1 | Output below the window (target minus 300 mV) |
| ov_i | input | 1 | Output above the window (target plus 200 mV) |
| crowbar_i | input | 1 | Crowbar overvoltage comparator |
| dac_vid_o | output | 1 | DAC target select: 0 boot voltage, 1 VID code |
| clk_en_n_o | output | 1 | Processor clock enable, active low |
| pgood_o | output | 1 | Power-good |
| sw_en_o | output | 1 | Power-stage switching enable |
| latch_o | output | 1 | Latchoff indication |

## Verification
Several properties are checked by assertions on every cycle:
- power-good never appears without the clock released;
- a falling clock enable only happens while switching;
- a latchoff holds all outputs safe and persists while enable stays high;
- enable low always yields the disabled state one edge later.

Exact delay lengths are shown only by the bench's directed scenarios. These cover the soft-start, boot, power-good and mask windows, and the three distinct latchoff delays. The scenarios also show the boundary between a fault that is just too short to latch and one that does latch, and the restart after an aborted sequence.

// File: rtl/vreg_seq_ctrl.sv
module vreg_seq_ctrl #(
  parameter int SS_DLY   = 20,
  parameter int BOOT_DLY = 12,
  parameter int PG_DLY   = 9,
  parameter int MASK_DLY = 10,
  parameter int WIN_DLY  = 9,
  parameter int OCP_DLY  = 15,
  parameter int CB_DLY   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic gpu_mode_i,
  input  logic ramp_done_i,
  input  logic vid_chg_i,
  input  logic ocp_i,
  input  logic uv_i,
  input  logic ov_i,
  input  logic crowbar_i,
  output logic dac_vid_o,
  output logic clk_en_n_o,
  output logic pgood_o,
  output logic sw_en_o,
  output logic latch_o
);

  localparam int M1   = (SS_DLY > BOOT_DLY) ? SS_DLY : BOOT_DLY;
  localparam int M2   = (PG_DLY > MASK_DLY) ? PG_DLY : MASK_DLY;
  localparam int M3   = (WIN_DLY > OCP_DLY) ? WIN_DLY : OCP_DLY;
  localparam int M4   = (M1 > M2) ? M1 : M2;
  localparam int M5   = (M3 > CB_DLY) ? M3 : CB_DLY;
  localparam int MAXD = (M4 > M5) ? M4 : M5;
  localparam int CW   = $clog2(MAXD + 1);

  typedef enum logic [2:0] {
    S_OFF, S_SOFT, S_RAMP, S_BOOT, S_PGW, S_RUN, S_LATCH
  } st_t;

  st_t st;
  logic [CW-1:0] seq_cnt, mask_cnt, win_cnt, oc_cnt, cb_cnt, lim;
  logic oc_q;

  wire running   = (st == S_RUN);
  wire clk_out   = (st == S_PGW) || running;
  wire switching = (st == S_RAMP) || (st == S_BOOT) || clk_out;
  wire powered   = switching || (st == S_SOFT);
  wire oc_rise   = ocp_i & ~oc_q;
  wire mask_now  = vid_chg_i | oc_rise | (mask_cnt != '0);
  wire win_bad   = running & (uv_i | ov_i) & ~mask_now;
  wire oc_on     = switching & ocp_i;
  wire cb_on     = powered & crowbar_i;
  wire win_trip  = win_bad && (win_cnt == CW'(WIN_DLY - 1));
  wire oc_trip   = oc_on && (oc_cnt == CW'(OCP_DLY - 1));
  wire cb_trip   = cb_on && (cb_cnt == CW'(CB_DLY - 1));
  wire seq_done  = (seq_cnt == lim);

  always_comb begin
    case (st)
      S_SOFT:  lim = CW'(SS_DLY - 1);
      S_BOOT:  lim = CW'(BOOT_DLY - 1);
      S_PGW:   lim = CW'(PG_DLY - 1);
      default: lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      seq_cnt  <= '0;
      mask_cnt <= '0;
      win_cnt  <= '0;
      oc_cnt   <= '0;
      cb_cnt   <= '0;
      oc_q     <= 1'b0;
    end else begin
      oc_q <= ocp_i;
      if (vid_chg_i || oc_rise)
        mask_cnt <= CW'(MASK_DLY);
      else if (mask_cnt != '0)
        mask_cnt <= mask_cnt - 1'b1;

      if (!en_i) begin
        st      <= S_OFF;
        seq_cnt <= '0;
        win_cnt <= '0;
        oc_cnt  <= '0;
        cb_cnt  <= '0;
      end else if (win_trip || oc_trip || cb_trip) begin
        st      <= S_LATCH;
        win_cnt <= '0;
        oc_cnt  <= '0;
        cb_cnt  <= '0;
      end else begin
        win_cnt <= win_bad ? win_cnt + 1'b1 : '0;
        oc_cnt  <= oc_on ? oc_cnt + 1'b1 : '0;
        cb_cnt  <= cb_on ? cb_cnt + 1'b1 : '0;
        case (st)
          S_OFF: begin
            st      <= S_SOFT;
            seq_cnt <= '0;
          end
          S_SOFT: begin
            if (seq_done) begin
              st      <= S_RAMP;
              seq_cnt <= '0;
            end else seq_cnt <= seq_cnt + 1'b1;
          end
          S_RAMP: begin
            if (ramp_done_i) begin
              st      <= gpu_mode_i ? S_PGW : S_BOOT;
              seq_cnt <= '0;
            end
          end
          S_BOOT: begin
            if (seq_done) begin
              st      <= S_PGW;
              seq_cnt <= '0;
            end else seq_cnt <= seq_cnt + 1'b1;
          end
          S_PGW: begin
            if (seq_done) begin
              st      <= S_RUN;
              seq_cnt <= '0;
            end else seq_cnt <= seq_cnt + 1'b1;
          end
          default: st <= st;
        endcase
      end
    end
  end

  assign sw_en_o    = switching;
  assign clk_en_n_o = ~clk_out;
  assign dac_vid_o  = gpu_mode_i | clk_out;
  assign pgood_o    = running & ~win_bad;
  assign latch_o    = (st == S_LATCH);

  // R1 / R11: enable low always yields the disabled state one edge later
  a_r11_disable_safe: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!sw_en_o && !pgood_o && clk_en_n_o && !latch_o));

  // R12: latchoff stays while enable stays high
  a_r12_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_o && en_i) |=> latch_o);

  // R8: a latched regulator keeps every output safe
  a_r8_latch_safe: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> (!sw_en_o && !pgood_o && clk_en_n_o));

  // R5: power-good only rises after the clock was already released
  a_r5_pgood_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_o) |-> $past(!clk_en_n_o));

  // R3: clock release only while the power stage switches
  a_r3_clk_needs_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_n_o) |-> sw_en_o);

  // R4: power-good implies the VID target is selected
  a_r4_pgood_vid: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_o |-> (dac_vid_o && !clk_en_n_o));

endmodule

// File: tb/sim_vreg_seq_ctrl.sv
module sim_vreg_seq_ctrl;
  localparam int SS = 20, BT = 12, PG = 9, MK = 10, WN = 9, OC = 15, CB = 2;

  logic clk = 0, rst_n = 0;
  logic en = 0, gpu = 0, rdone = 0, vchg = 0, ocp = 0, uv = 0, ov = 0, cbar = 0;
  logic dac_vid, clk_en_n, pgood, sw_en, latched;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  vreg_seq_ctrl #(.SS_DLY(SS), .BOOT_DLY(BT), .PG_DLY(PG), .MASK_DLY(MK),
                  .WIN_DLY(WN), .OCP_DLY(OC), .CB_DLY(CB)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .gpu_mode_i(gpu), .ramp_done_i(rdone),
    .vid_chg_i(vchg), .ocp_i(ocp), .uv_i(uv), .ov_i(ov), .crowbar_i(cbar),
    .dac_vid_o(dac_vid), .clk_en_n_o(clk_en_n), .pgood_o(pgood),
    .sw_en_o(sw_en), .latch_o(latched));

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_off(input string req);
    chk(req, "sw_en", sw_en, 0);
    chk(req, "pgood", pgood, 0);
    chk(req, "clk_en_n", clk_en_n, 1);
  endtask

  // 0 sw_en high, 1 clk_en_n low, 2 pgood high, 3 latched high
  task automatic count_edges(input int sel, output int n);
    bit hit;
    n = 0;
    hit = 0;
    while (!hit && n < 500) begin
      @(posedge clk); #1;
      n++;
      case (sel)
        0: hit = sw_en;
        1: hit = !clk_en_n;
        2: hit = pgood;
        default: hit = latched;
      endcase
    end
  endtask

  task automatic quiesce;
    @(negedge clk);
    en = 0; rdone = 0; vchg = 0; ocp = 0; uv = 0; ov = 0; cbar = 0;
    @(posedge clk); #1;
  endtask

  task automatic bring_up(input bit g);
    int n;
    @(negedge clk);
    gpu = g; en = 1;
    count_edges(0, n);
    chk("R2", "soft-start edges", n, SS + 1);
    if (g) chk("R4", "dac select during ramp", dac_vid, 1);
    else   chk("R3", "dac select during ramp", dac_vid, 0);
    @(negedge clk);
    rdone = 1;
    count_edges(1, n);
    if (g) chk("R4", "edges to clock release", n, 1);
    else   chk("R3", "edges to clock release", n, BT + 1);
    chk(g ? "R4" : "R3", "dac select after release", dac_vid, 1);
    count_edges(2, n);
    chk("R5", "edges to power-good", n, PG);
  endtask

  task automatic t_reset;
    #1;
    chk_off("R1");
    chk("R1", "latch in reset", latched, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk); #1;
    chk_off("R1");
  endtask

  task automatic t_window;
    int n;
    bring_up(0);
    @(negedge clk); uv = 1; #1;
    chk("R6", "pgood on undervoltage", pgood, 0);
    @(negedge clk); uv = 0; #1;
    chk("R6", "pgood after clear", pgood, 1);
    @(negedge clk); ov = 1;
    repeat (WN - 1) @(posedge clk);
    @(negedge clk); ov = 0; #1;
    chk("R8", "short fault latch", latched, 0);
    chk("R8", "pgood after short fault", pgood, 1);
    @(negedge clk); uv = 1;
    count_edges(3, n);
    chk("R8", "edges to window latch", n, WN);
    chk_off("R8");
    @(negedge clk); uv = 0;
    repeat (6) @(posedge clk); #1;
    chk("R12", "latch held", latched, 1);
    chk("R12", "sw_en held off", sw_en, 0);
    quiesce();
    chk("R11", "latch cleared by enable low", latched, 0);
    chk_off("R11");
  endtask

  task automatic t_mask;
    int n;
    bring_up(0);
    @(negedge clk); vchg = 1; uv = 1; #1;
    chk("R7", "pgood in event cycle", pgood, 1);
    n = 0;
    @(posedge clk); #1; vchg = 0;
    while (pgood && n < 100) begin
      n++;
      @(posedge clk); #1;
    end
    chk("R7", "masked cycles after event", n, MK);
    uv = 0; #1;
    chk("R7", "no latch after mask", latched, 0);
    chk("R7", "pgood back", pgood, 1);
    quiesce();
  endtask

  task automatic t_ocp;
    int n;
    bring_up(0);
    @(negedge clk); ocp = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); ocp = 0; #1;
    chk("R9", "short over-current latch", latched, 0);
    chk("R9", "pgood after short over-current", pgood, 1);
    @(negedge clk); ocp = 1;
    count_edges(3, n);
    chk("R9", "edges to over-current latch", n, OC);
    chk_off("R9");
    quiesce();
  endtask

  task automatic t_crowbar;
    int n;
    @(negedge clk); gpu = 0; en = 1;
    repeat (4) @(posedge clk);
    @(negedge clk); cbar = 1;
    count_edges(3, n);
    chk("R10", "edges to crowbar latch in soft-start", n, CB);
    chk("R10", "switching stays off", sw_en, 0);
    quiesce();
    bring_up(0);
    @(negedge clk); vchg = 1; cbar = 1;
    @(posedge clk); #1; vchg = 0;
    n = 1;
    if (!latched) begin
      count_edges(3, n);
      n++;
    end
    chk("R10", "crowbar latch despite mask", n, CB);
    quiesce();
  endtask

  task automatic t_abort;
    int n;
    @(negedge clk); gpu = 0; en = 1;
    count_edges(0, n);
    @(negedge clk); rdone = 1;
    repeat (4) @(posedge clk);
    @(negedge clk); en = 0; rdone = 0;
    @(posedge clk); #1;
    chk_off("R11");
    @(posedge clk);
    bring_up(0);
    quiesce();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (sequence hung) actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_window();
    t_mask();
    t_ocp();
    t_crowbar();
    bring_up(1);
    quiesce();
    t_abort();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule